// File: doc/BRIEF.md
# Burst Dimming and Blanking Sequencer

This block sets lamp brightness by switching the lamp drive on and off at a low repetition rate. A free-running phase counter spans one dimming period. Comparing that counter with a brightness code produces the `chop` signal. A larger code keeps the lamp on for more of each period, and the all-ones code keeps it on all the time. The lamp is lit when `chop` is high and the external fault input is low.

Each time the lamp lights, two digital ramps restart from zero. The blanking ramp holds `blank` high until it passes three fifths of full scale. While `blank` is high, the downstream undervoltage and undercurrent checks ignore their inputs. The soft-start ramp caps the duty command that goes to the PWM stage, so the duty command starts every burst at zero.

In the first burst after enable or reset, the blanking ramp advances only once every `SLOW_DIV` lit cycles. This gives a cold lamp much more time to strike. `first_cycle` marks that burst. All pins are plain level signals with no handshake: inputs are sampled on every clock, and outputs follow within the cycle or one clock later, as stated below.

Top module: `burst_dim_seq`

## Requirements
- R1: While `enable` is low, `chop`, `first_cycle` and `duty_cmd` are zero and `blank` is high. On the first enabled cycle the phase counter, both ramps and the first-burst state start from their reset values (counter 0, ramps 0, first burst armed).
- R2: The phase counter starts at 0 and adds 1 on every enabled clock, wrapping after 2^PERIOD_W counts. `chop` is high exactly when the counter value is below `bright_code`, so a code of 0 never lights the lamp.
- R3: When `bright_code` is all ones, `chop` stays high on every enabled cycle.
- R4: The lamp is lit when `chop` is high and `fault_in` is low. On any clock edge at which the lamp is not lit, both ramp levels become 0.
- R5: `blank` is high exactly when the blanking ramp level is below floor(3*2^RAMP_W/5), which is 153 for RAMP_W=8.
- R6: Outside the first burst, the blanking ramp adds `blank_step` on every lit clock edge and saturates at 2^RAMP_W-1.
- R7: In the first burst, the blanking ramp adds `blank_step` only on every SLOW_DIV-th lit edge (SLOW_DIV defaults to 150). The prescaler restarts at 0 whenever the lamp is off.
- R8: `first_cycle` is high only while the lamp is lit during the first burst after enable or reset. The first burst ends at the first clock edge at which the lamp is off after having been lit.
- R9: The soft-start ramp adds `soft_step` on every lit clock edge, in every burst including the first, and saturates at 2^RAMP_W-1.
- R10: `duty_cmd` equals the smaller of `duty_req` and the soft-start ramp level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds all state at reset values |
| fault_in | input | 1 | High forces the lamp off |
| bright_code | input | PERIOD_W | Brightness code |
| blank_step | input | RAMP_W | Blanking ramp increment |
| soft_step | input | RAMP_W | Soft-start ramp increment |
| duty_req | input | RAMP_W | Duty requested by the regulation loop |
| chop | output | 1 | Burst on/off signal |
| blank | output | 1 | Hold-off for the undervoltage and undercurrent checks |
| first_cycle | output | 1 | Lamp lit in the first burst after enable |
| duty_cmd | output | RAMP_W | Duty command after the soft-start cap |

## Verification
The stimulus starts with a mid-range brightness code. This contrasts the slow first blanking ramp with the fast ramps of later bursts. A run with the all-ones code never turns the lamp off, so the first burst lasts long enough for its slow blanking to run to the end. Codes 0 and 1 bound the on-time at none and a single cycle per period. A low `duty_req` separates the loop-limited duty command from the ramp-limited one. Fault pulses, a toggle of `enable` and a reset mid-run show which events end the first burst and restart the ramps. Large step values exercise saturation of both ramps.

// File: rtl/bdim_pkg.sv
package bdim_pkg;
  // Blanking ends at three fifths of the ramp's full scale.
  function automatic int unsigned blank_thresh(int unsigned w);
    return (3 * (32'd1 << w)) / 5;
  endfunction

  typedef enum logic {RATE_FAST = 1'b0, RATE_SLOW = 1'b1} rate_e;
endpackage

// File: rtl/bdim_period.sv
module bdim_period #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] bright_code,
  output logic                chop
);
  logic [PERIOD_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!enable) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    chop = enable && ((&bright_code) || (phase_q < bright_code));
  end
endmodule

// File: rtl/bdim_ramp.sv
module bdim_ramp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] step,
  output logic [W-1:0] level
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, level} + {1'b0, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (clear)  level <= '0;
    else if (tick)   level <= sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/bdim_first.sv
module bdim_first #(
  parameter int SLOW_DIV = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lamp_on,
  output bdim_pkg::rate_e rate,
  output logic slow_tick
);
  localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic          armed_q;
  logic          lamp_q;
  logic [PW-1:0] presc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      lamp_q  <= 1'b0;
      presc_q <= '0;
    end else if (!enable) begin
      armed_q <= 1'b1;
      lamp_q  <= 1'b0;
      presc_q <= '0;
    end else begin
      lamp_q <= lamp_on;
      if (lamp_q && !lamp_on) armed_q <= 1'b0;
      if (!lamp_on)           presc_q <= '0;
      else if (armed_q)       presc_q <= slow_tick ? '0 : presc_q + 1'b1;
    end
  end

  always_comb begin
    rate      = armed_q ? bdim_pkg::RATE_SLOW : bdim_pkg::RATE_FAST;
    slow_tick = lamp_on && armed_q && (presc_q == PW'(SLOW_DIV - 1));
  end
endmodule

// File: rtl/burst_dim_seq.sv
module burst_dim_seq #(
  parameter int PERIOD_W = 16,
  parameter int RAMP_W   = 8,
  parameter int SLOW_DIV = 150
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                fault_in,
  input  logic [PERIOD_W-1:0] bright_code,
  input  logic [RAMP_W-1:0]   blank_step,
  input  logic [RAMP_W-1:0]   soft_step,
  input  logic [RAMP_W-1:0]   duty_req,
  output logic                chop,
  output logic                blank,
  output logic                first_cycle,
  output logic [RAMP_W-1:0]   duty_cmd
);
  localparam int unsigned BLANK_TH = bdim_pkg::blank_thresh(RAMP_W);

  logic              lamp_on;
  logic              slow_tick;
  logic              blank_tick;
  bdim_pkg::rate_e   rate;
  logic [RAMP_W-1:0] blank_lvl;
  logic [RAMP_W-1:0] soft_lvl;

  bdim_period #(.PERIOD_W(PERIOD_W)) u_period (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .bright_code(bright_code), .chop(chop)
  );

  assign lamp_on = chop && !fault_in;

  bdim_first #(.SLOW_DIV(SLOW_DIV)) u_first (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lamp_on(lamp_on),
    .rate(rate), .slow_tick(slow_tick)
  );

  assign blank_tick = (rate == bdim_pkg::RATE_SLOW) ? slow_tick : lamp_on;

  bdim_ramp #(.W(RAMP_W)) u_blank_ramp (
    .clk(clk), .rst_n(rst_n), .clear(!lamp_on), .tick(blank_tick),
    .step(blank_step), .level(blank_lvl)
  );

  bdim_ramp #(.W(RAMP_W)) u_soft_ramp (
    .clk(clk), .rst_n(rst_n), .clear(!lamp_on), .tick(lamp_on),
    .step(soft_step), .level(soft_lvl)
  );

  always_comb begin
    blank       = blank_lvl < RAMP_W'(BLANK_TH);
    first_cycle = lamp_on && (rate == bdim_pkg::RATE_SLOW);
    duty_cmd    = (duty_req < soft_lvl) ? duty_req : soft_lvl;
  end
endmodule

// File: rtl/bdim_chk.sv
module bdim_chk #(
  parameter int PERIOD_W = 16,
  parameter int RAMP_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                fault_in,
  input logic [PERIOD_W-1:0] bright_code,
  input logic [RAMP_W-1:0]   duty_req,
  input logic                chop,
  input logic                first_cycle,
  input logic [RAMP_W-1:0]   duty_cmd,
  input logic [RAMP_W-1:0]   blank_lvl,
  input logic [RAMP_W-1:0]   soft_lvl
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!chop && duty_cmd == '0 && !first_cycle));

  assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bright_code == '0) |-> !chop);

  assert_full_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (&bright_code)) |-> chop);

  assert_off_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(chop && !fault_in) |=> (blank_lvl == '0 && soft_lvl == '0));

  assert_blank_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chop && !fault_in) |=> (blank_lvl >= $past(blank_lvl)));

  assert_first_lit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    first_cycle |-> (chop && !fault_in));

  assert_soft_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chop && !fault_in) |=> (soft_lvl >= $past(soft_lvl)));

  assert_duty_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cmd <= duty_req) && (duty_cmd <= soft_lvl));
endmodule

bind burst_dim_seq bdim_chk #(.PERIOD_W(PERIOD_W), .RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fault_in(fault_in),
  .bright_code(bright_code), .duty_req(duty_req), .chop(chop),
  .first_cycle(first_cycle), .duty_cmd(duty_cmd),
  .blank_lvl(blank_lvl), .soft_lvl(soft_lvl)
);

// File: tb/burst_dim_seq_tb_top.sv
module burst_dim_seq_tb_top;
  localparam int PW = 6;
  localparam int RW = 8;
  localparam int DIV = 150;
  localparam int TH = (3 * 256) / 5;
  localparam int MAXR = 255;
  localparam int FULL = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic fault_in = 1'b0;
  logic [PW-1:0] bright_code = '0;
  logic [RW-1:0] blank_step = '0, soft_step = '0, duty_req = '0;
  logic chop, blank, first_cycle;
  logic [RW-1:0] duty_cmd;

  // stimulus settings, applied at the next falling edge
  logic st_rst = 1'b0, st_en = 1'b0, st_fault = 1'b0;
  int st_code = 0, st_bs = 0, st_ss = 0, st_req = 0;

  // reference model state
  int m_cnt = 0, m_br = 0, m_sr = 0, m_pre = 0;
  bit m_arm = 1'b1, m_lq = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_dim_seq #(.PERIOD_W(PW), .RAMP_W(RW), .SLOW_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault_in(fault_in),
    .bright_code(bright_code), .blank_step(blank_step), .soft_step(soft_step),
    .duty_req(duty_req), .chop(chop), .blank(blank),
    .first_cycle(first_cycle), .duty_cmd(duty_cmd)
  );

  function automatic int sat(int v);
    return (v > MAXR) ? MAXR : v;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_n = st_rst; enable = st_en; fault_in = st_fault;
      bright_code = PW'(st_code); blank_step = RW'(st_bs);
      soft_step = RW'(st_ss); duty_req = RW'(st_req);
      if (!st_rst) begin
        m_cnt = 0; m_br = 0; m_sr = 0; m_pre = 0; m_arm = 1'b1; m_lq = 1'b0;
      end
      #1;
      begin
        bit e_chop, e_lamp;
        int e_duty;
        string ctag;
        e_chop = st_en && (st_code == FULL || m_cnt < st_code);
        e_lamp = e_chop && !st_fault;
        e_duty = (st_req < m_sr) ? st_req : m_sr;
        ctag = !st_en ? "R1" : (st_code == FULL ? "R3" : "R2");
        check(ctag, "chop", chop, e_chop);
        // R5 threshold, R6 fast and R7 slow rate, R4 clearing
        check(m_arm ? "R7" : "R6", "blank", blank, m_br < TH);
        check("R8", "first_cycle", first_cycle, m_arm && e_lamp);
        // R9 soft-start ramp through R10 minimum
        check("R10", "duty_cmd", duty_cmd, e_duty);
        if (st_rst) begin
          if (!st_en) begin
            m_cnt = 0; m_br = 0; m_sr = 0; m_pre = 0; m_arm = 1'b1; m_lq = 1'b0;
          end else begin
            m_cnt = (m_cnt + 1) % (FULL + 1);
            if (e_lamp) begin
              m_sr = sat(m_sr + st_ss);
              if (m_arm) begin
                if (m_pre == DIV - 1) begin
                  m_pre = 0; m_br = sat(m_br + st_bs);
                end else m_pre++;
              end else m_br = sat(m_br + st_bs);
            end else begin
              m_br = 0; m_sr = 0; m_pre = 0;
              if (m_lq) m_arm = 1'b0;
            end
            m_lq = e_lamp;
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run(3);
    st_rst = 1'b1; run(5);                         // R1 idle state
    st_en = 1'b1; st_code = 40; st_bs = 20; st_ss = 16; st_req = 200;
    run(400);                                      // R2, R7 first burst, R6 later
    st_req = 50; run(200);                         // R10 loop-limited
    st_code = FULL; run(300);                      // R3
    st_code = 0; run(200);                         // R2 never lit
    st_en = 1'b0; run(3);                          // R1 re-arm
    st_en = 1'b1; st_code = FULL; st_req = 255; run(1500); // R7 slow blanking
    st_fault = 1'b1; run(5);                       // R4 fault clears ramps
    st_fault = 1'b0; run(300);                     // R8 first burst over, R6 fast
    st_bs = 200; st_ss = 255; st_code = 50; run(200); // R6, R9 saturation
    st_code = 1; run(200);                         // R2 one-cycle bursts
    st_rst = 1'b0; run(2);
    st_rst = 1'b1; st_code = 30; st_bs = 5; st_ss = 3; st_req = 100; run(600);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule